// File: doc/BRIEF.md
# Warp Issue Sequencer

The block is the front end of a streaming multiprocessor. It keeps a program counter for each of a set of resident thread groups (warps) of 32 threads. At every instruction slot boundary it picks one warp whose ready flag is high. It then steps that warp's instruction across a narrow bank of 8 processing lanes in four consecutive beats: threads 0-7 first, then 8-15, then 16-23, then 24-31. Each beat presents a lane enable vector, the thread index each lane serves, the warp number and its program counter.

Divergence reaches the block only as a 32-bit active mask per warp. The mask is captured when the slot starts and gates the lane enables for all four beats. A warp that waits on memory drops its ready flag and is skipped until the flag returns. Because a different warp may be chosen for every slot, memory latency is hidden behind the other warps' work. Arithmetic units, register file contents and memory are outside the block.

The beats leave on a valid/ready stream. A beat is transferred on a clock edge where both `iss_valid` and `iss_ready` are high. While `iss_valid` is high and `iss_ready` is low, every issue output holds its value. The block never withdraws a beat it has offered.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset, `iss_valid` and `lane_en` are low and every warp's program counter is 0. The first slot goes to the lowest-numbered ready warp.
- R2: A slot is four accepted beats of one warp, with `iss_group` taking the values 0, 1, 2, 3 in that order. On every beat, lane l has `lane_tid` field l (5 bits at position 5*l) equal to 8*`iss_group` + l.
- R3: On each beat, `lane_en` bit l equals bit 8*`iss_group` + l of the warp's `warp_mask` slice (bits 32*w to 32*w+31) as sampled on the edge that started the slot. Mask changes during the slot have no effect.
- R4: At a slot boundary, the chosen warp is the first ready warp after the previously issued warp, in increasing index order and wrapping from 23 to 0.
- R5: A warp whose `warp_ready` bit is low on the boundary edge is not chosen for that slot.
- R6: `iss_pc` shows the issuing warp's counter, which stays constant through the slot. The counter increments by one after the fourth beat is accepted. Other warps' counters do not change.
- R7: If no warp is ready at a boundary, `iss_valid` goes low and the choice is made again on every following edge.
- R8: While `iss_valid` is high and `iss_ready` is low, `iss_warp`, `iss_group`, `iss_pc`, `lane_en` and `lane_tid` hold, and `iss_valid` stays high.
- R9: When the fourth beat is accepted and some warp is ready, the next slot's first beat is offered on the next cycle with no gap.
- R10: `lane_en` is all zero whenever `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | 24 | Per-warp eligibility; low while the warp waits on memory |
| warp_mask | input | 768 | Per-warp 32-bit active thread mask, warp w in bits 32*w+31 to 32*w |
| iss_ready | input | 1 | Downstream accepts the current beat |
| iss_valid | output | 1 | A beat is offered |
| iss_warp | output | 5 | Warp of the current beat |
| iss_pc | output | 16 | Program counter of the issuing warp |
| iss_group | output | 2 | Lane group index 0..3 within the slot |
| iss_last | output | 1 | Current beat is the fourth of its slot |
| lane_en | output | 8 | Per-lane enable for the current beat |
| lane_tid | output | 40 | Per-lane thread index, 5 bits per lane |

## Verification
The hardest case to reach is a stall on the fourth beat while ready flags and masks keep changing. The arbitration must then use the flags present on the edge where the beat is finally accepted, and it must continue from the stalled warp. The stimulus creates this case by toggling `iss_ready` and every ready flag at random on each cycle while rewriting all masks. Directed phases force an empty ready set, a full ready set that wraps from warp 23 to warp 0, and a sparse set of two warps.

// File: rtl/wis_pkg.sv
package wis_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;

  // modular add of a small step to an index below modulus
  function automatic int wrap_add(input int base, input int step, input int modulus);
    int s;
    s = base + step;
    if (s >= modulus) s = s - modulus;
    return s;
  endfunction

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  import wis_pkg::*;

  // scan from farthest to nearest so the nearest requester after base wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N; k >= 1; k--) begin
      if (req[wrap_add(int'(base), k, N)]) begin
        found = 1'b1;
        pick  = IDX_W'(wrap_add(int'(base), k, N));
      end
    end
  end

endmodule

// File: rtl/wis_pc_bank.sv
module wis_pc_bank #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N),
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_pc
);

  logic [PC_W-1:0] pc_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc_q[g] <= '0;
      else if (inc_en && (inc_idx == IDX_W'(g)))
        pc_q[g] <= pc_q[g] + PC_W'(1);
    end
  end

  assign rd_pc = pc_q[rd_idx];

endmodule

// File: rtl/wis_lane_gen.sv
module wis_lane_gen #(
  parameter int LANES   = 8,
  parameter int THREADS = 32,
  parameter int GRP_W   = 2,
  parameter int TID_W   = $clog2(THREADS)
) (
  input  logic                   active,
  input  logic [GRP_W-1:0]       grp,
  input  logic [THREADS-1:0]     mask,
  output logic [LANES-1:0]       lane_en,
  output logic [LANES*TID_W-1:0] lane_tid
);

  logic [LANES-1:0] grp_bits;

  always_comb grp_bits = mask[int'(grp)*LANES +: LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = active & grp_bits[l];
    assign lane_tid[l*TID_W +: TID_W] = TID_W'(int'(grp) * LANES + l);
  end

endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq #(
  parameter int NUM_WARPS    = 24,
  parameter int WARP_THREADS = 32,
  parameter int LANES        = 8,
  parameter int PC_W         = 16,
  localparam int WID_W       = $clog2(NUM_WARPS),
  localparam int GROUPS      = WARP_THREADS / LANES,
  localparam int GRP_W       = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int TID_W       = $clog2(WARP_THREADS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WARPS-1:0]              warp_ready,
  input  logic [NUM_WARPS*WARP_THREADS-1:0] warp_mask,
  input  logic                              iss_ready,
  output logic                              iss_valid,
  output logic [WID_W-1:0]                  iss_warp,
  output logic [PC_W-1:0]                   iss_pc,
  output logic [GRP_W-1:0]                  iss_group,
  output logic                              iss_last,
  output logic [LANES-1:0]                  lane_en,
  output logic [LANES*TID_W-1:0]            lane_tid
);
  import wis_pkg::*;

  seq_state_e              state_q;
  logic [WID_W-1:0]        warp_q;
  logic [GRP_W-1:0]        grp_q;
  logic [WARP_THREADS-1:0] mask_q;

  logic             beat_done, slot_end, boundary, found;
  logic [WID_W-1:0] pick;

  assign beat_done = (state_q == SEQ_ISSUE) && iss_ready;
  assign slot_end  = beat_done && (grp_q == GRP_W'(GROUPS - 1));
  assign boundary  = (state_q == SEQ_IDLE) || slot_end;

  // warp_q keeps the last issued warp and is the arbitration base
  wis_rr_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) i_pick (
    .req   (warp_ready),
    .base  (warp_q),
    .found (found),
    .pick  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      warp_q  <= WID_W'(NUM_WARPS - 1);
      grp_q   <= '0;
      mask_q  <= '0;
    end else if (boundary) begin
      if (found) begin
        state_q <= SEQ_ISSUE;
        warp_q  <= pick;
        grp_q   <= '0;
        mask_q  <= warp_mask[int'(pick)*WARP_THREADS +: WARP_THREADS];
      end else begin
        state_q <= SEQ_IDLE;
      end
    end else if (beat_done) begin
      grp_q <= grp_q + GRP_W'(1);
    end
  end

  wis_pc_bank #(.N(NUM_WARPS), .IDX_W(WID_W), .PC_W(PC_W)) i_pcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (slot_end),
    .inc_idx (warp_q),
    .rd_idx  (warp_q),
    .rd_pc   (iss_pc)
  );

  wis_lane_gen #(
    .LANES(LANES), .THREADS(WARP_THREADS), .GRP_W(GRP_W), .TID_W(TID_W)
  ) i_lanes (
    .active   (state_q == SEQ_ISSUE),
    .grp      (grp_q),
    .mask     (mask_q),
    .lane_en  (lane_en),
    .lane_tid (lane_tid)
  );

  assign iss_valid = (state_q == SEQ_ISSUE);
  assign iss_warp  = warp_q;
  assign iss_group = grp_q;
  assign iss_last  = iss_valid && (grp_q == GRP_W'(GROUPS - 1));

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 24,
  parameter int WID_W     = 5,
  parameter int GRP_W     = 2,
  parameter int PC_W      = 16,
  parameter int LANES     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_ready,
  input logic                 iss_ready,
  input logic                 iss_valid,
  input logic [WID_W-1:0]     iss_warp,
  input logic [PC_W-1:0]      iss_pc,
  input logic [GRP_W-1:0]     iss_group,
  input logic                 iss_last,
  input logic [LANES-1:0]     lane_en
);

  logic [NUM_WARPS-1:0] rdy_d;
  logic                 fin_d, valid_d, new_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_d   <= '0;
      fin_d   <= 1'b0;
      valid_d <= 1'b0;
    end else begin
      rdy_d   <= warp_ready;
      fin_d   <= iss_valid && iss_ready && iss_last;
      valid_d <= iss_valid;
    end
  end

  assign new_slot = iss_valid && (!valid_d || fin_d);

  a_r5_pick_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
    new_slot |-> rdy_d[iss_warp]);

  a_r2_slot_starts_group0: assert property (@(posedge clk) disable iff (!rst_n)
    new_slot |-> (iss_group == '0));

  a_r2_group_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_last) |=>
      (iss_valid && (iss_warp == $past(iss_warp)) &&
       (iss_group == $past(iss_group) + GRP_W'(1))));

  a_r6_pc_steady_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_last) |=> $stable(iss_pc));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=>
      (iss_valid && $stable(iss_warp) && $stable(iss_group) &&
       $stable(lane_en) && $stable(iss_pc)));

  a_r7_idle_when_none_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((!iss_valid || (iss_ready && iss_last)) && (warp_ready == '0)) |=> !iss_valid);

  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_last && (warp_ready != '0)) |=>
      (iss_valid && (iss_group == '0)));

  a_r10_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (lane_en == '0));

endmodule

bind warp_issue_seq wis_checker #(
  .NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .GRP_W(GRP_W), .PC_W(PC_W), .LANES(LANES)
) i_wis_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .warp_ready (warp_ready),
  .iss_ready  (iss_ready),
  .iss_valid  (iss_valid),
  .iss_warp   (iss_warp),
  .iss_pc     (iss_pc),
  .iss_group  (iss_group),
  .iss_last   (iss_last),
  .lane_en    (lane_en)
);

// File: tb/test_warp_issue_seq.sv
`timescale 1ns/1ps
module test_warp_issue_seq;
  localparam int NW = 24;
  localparam int NT = 32;
  localparam int NL = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NW-1:0]  warp_ready = '0;
  logic [NW*NT-1:0] warp_mask = '0;
  logic           iss_ready = 1'b0;
  logic           iss_valid;
  logic [4:0]     iss_warp;
  logic [15:0]    iss_pc;
  logic [1:0]     iss_group;
  logic           iss_last;
  logic [NL-1:0]  lane_en;
  logic [NL*5-1:0] lane_tid;

  always #2.5 clk = ~clk;

  warp_issue_seq i_warp_issue_seq (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_mask(warp_mask),
    .iss_ready(iss_ready), .iss_valid(iss_valid), .iss_warp(iss_warp),
    .iss_pc(iss_pc), .iss_group(iss_group), .iss_last(iss_last),
    .lane_en(lane_en), .lane_tid(lane_tid)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // reference state
  bit          m_busy = 1'b0;
  int          m_warp = NW - 1;
  int          m_grp = 0;
  logic [31:0] m_mask = '0;
  int          m_pc [NW];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_tid(input int grp);
    logic [39:0] v;
    for (int l = 0; l < NL; l++) v[l*5 +: 5] = 5'(grp * NL + l);
    return v;
  endfunction

  task automatic compare(input string ph);
    check({"R7/", ph}, 64'(iss_valid), 64'(m_busy));
    if (m_busy) begin
      check({"R4/", ph}, 64'(iss_warp), 64'(m_warp));
      check({"R2/", ph}, 64'(iss_group), 64'(m_grp));
      check({"R2/", ph}, 64'(iss_last), 64'(m_grp == 3));
      check({"R2/", ph}, 64'(lane_tid), 64'(exp_tid(m_grp)));
      check({"R3/", ph}, 64'(lane_en), 64'(m_mask[m_grp*NL +: NL]));
      check({"R6/", ph}, 64'(iss_pc), 64'(m_pc[m_warp]));
    end else begin
      check({"R10/", ph}, 64'(lane_en), 64'd0);
    end
  endtask

  task automatic drive(input int mode);
    for (int w = 0; w < NW; w++) warp_mask[w*NT +: NT] = $urandom;
    case (mode)
      0: begin warp_ready = '0; iss_ready = 1'b1; end
      1: begin warp_ready = '1; iss_ready = 1'b1; end
      2: begin warp_ready = '0; warp_ready[5] = 1'b1; warp_ready[17] = 1'b1; iss_ready = 1'b1; end
      3: begin
        for (int w = 0; w < NW; w++) warp_ready[w] = ($urandom % 4) == 0;
        iss_ready = 1'b1;
      end
      default: begin
        for (int w = 0; w < NW; w++) warp_ready[w] = ($urandom % 10) < 3;
        iss_ready = $urandom % 2;
      end
    endcase
  endtask

  // advance reference across the coming edge using the inputs just driven
  task automatic model_step();
    bit hs;
    bit found;
    int pk;
    hs = m_busy && iss_ready;
    if (!m_busy || (hs && m_grp == 3)) begin
      if (hs) m_pc[m_warp] = (m_pc[m_warp] + 1) & 16'hFFFF;
      found = 1'b0;
      pk = 0;
      for (int k = NW; k >= 1; k--) begin
        if (warp_ready[(m_warp + k) % NW]) begin
          found = 1'b1;
          pk = (m_warp + k) % NW;
        end
      end
      if (found) begin
        m_busy = 1'b1;
        m_warp = pk;
        m_grp = 0;
        m_mask = warp_mask[pk*NT +: NT];
      end else begin
        m_busy = 1'b0;
      end
    end else if (hs) begin
      m_grp++;
    end
  endtask

  task automatic run(input int mode, input int cycles, input string ph);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare(ph);
      drive(mode);
      model_step();
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(20250);
    for (int w = 0; w < NW; w++) m_pc[w] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 64'(iss_valid), 64'd0);
    check("R1", 64'(lane_en), 64'd0);
    rst_n = 1'b1;
    drive(1);          // R1: all ready at release, warp 0 must go first
    model_step();
    run(1, 1, "R1");
    run(1, 100, "R9");  // back-to-back slots, wrap 23 -> 0
    run(0, 12, "R7");   // nothing ready
    run(2, 40, "R5");   // only warps 5 and 17 eligible
    run(3, 200, "R3");  // masks rewritten every cycle during slots
    run(4, 3000, "R8"); // random stalls and ready flags
    run(3, 1500, "R4");
    run(4, 3000, "R8");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule